// File: doc/BRIEF.md
# Pattern Page Mapper

This block maps the 8 KB pattern space seen by a video engine onto a much larger character ROM, one 1 KB page at a time. Eight 16-bit bank numbers are held in the block. Each is built from a low byte and a high byte that the CPU writes separately. A two-bit granularity field chooses how those bank numbers cover the space: one 8 KB window, two 4 KB windows, four 2 KB windows or eight 1 KB windows. Each granularity reads its own subset of the eight bank numbers and scales it by its own shift.

The video side presents a 13-bit pattern address. Bits 12:10 pick the 1 KB slot. The slot's page is reduced modulo the number of ROM pages and joined with address bits 9:0 to form the registered ROM byte address. The same register port also loads a two-bit nametable mirroring code, which the block drives straight out.

Top module: `pattern_page_mapper`

## Requirements
- R1: A write whose address, ANDed with 0xF007, equals 0x9000+n (n = 0..7) loads the low byte of bank n. One that equals 0xA000+n loads the high byte of bank n. Bank n is high×256 + low.
- R2: A write to masked address 0xD000 sets the granularity to data bits 4:3. All other data bits of that write have no effect.
- R3: At granularity 0, slot s (0..7) uses page bank0×8 + s.
- R4: At granularity 1, slots 0..3 use bank0×4 + s, and slots 4..7 use bank4×4 + (s−4).
- R5: At granularity 2, slots 2k and 2k+1 use bank(2k)×2 and bank(2k)×2 + 1, for k = 0..3.
- R6: At granularity 3, slot s uses bank s unchanged.
- R7: A write to masked address 0xD001 sets the mirroring output to data bits 1:0. The codes are 0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper.
- R8: Synchronous reset clears every bank byte, the granularity, the mirroring code (vertical) and the ROM address.
- R9: The slot is pattern address bits 12:10. The page arithmetic wraps at 16 bits. One clock after the pattern address is presented, the ROM address equals (page mod PAGE_COUNT)×1024 + pattern address bits 9:0.
- R10: A write whose masked address matches none of the above changes nothing. Address bits cleared by the mask are ignored, so 0x9FF8 aliases the low byte of bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| vid_addr | input | 13 | Pattern-space address from the video engine |
| rom_addr | output | 19 | Character ROM byte address, registered |
| mirror_sel | output | 2 | Nametable mirroring code |

## Verification
The bench tries the mapping with random bank bytes, random granularities and random pattern addresses, so that every slot is seen under every granularity. A mistake in the register subset or in the shift then shows up as a wrong page. High bytes are often left small and are sometimes set large. This separates a correct 16-bit bank build and modulo fold from one that drops the high byte or misses the 16-bit wrap. Directed cases cover aliasing and unmapped writes, ignored control bits, all four mirroring codes, and a page at 0xFFFF.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
  typedef enum logic [1:0] {
    GRAN_8K = 2'd0,
    GRAN_4K = 2'd1,
    GRAN_2K = 2'd2,
    GRAN_1K = 2'd3
  } gran_e;

  localparam logic [15:0] DEC_MASK  = 16'hF007;
  localparam logic [15:0] LO_BASE   = 16'h9000;
  localparam logic [15:0] HI_BASE   = 16'hA000;
  localparam logic [15:0] CTRL_ADDR = 16'hD000;
  localparam logic [15:0] MIRR_ADDR = 16'hD001;
endpackage

// File: rtl/chrmap_regs.sv
module chrmap_regs
  import chrmap_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [15:0]                       wr_addr,
  input  logic [7:0]                        wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks,
  output gran_e                             mode_q,
  output logic [1:0]                        mirror_q
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  logic [15:0] masked;
  logic        lo_hit, hi_hit, ctrl_hit, mirr_hit;

  assign masked   = wr_addr & DEC_MASK;
  assign lo_hit   = wr_en && (masked[15:3] == LO_BASE[15:3]);
  assign hi_hit   = wr_en && (masked[15:3] == HI_BASE[15:3]);
  assign ctrl_hit = wr_en && (masked == CTRL_ADDR);
  assign mirr_hit = wr_en && (masked == MIRR_ADDR);

  // One byte pair per bank; each pair decodes its own index
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [7:0] lo_q, hi_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_hit && masked[IDX_W-1:0] == IDX_W'(g)) lo_q <= wr_data;
        if (hi_hit && masked[IDX_W-1:0] == IDX_W'(g)) hi_q <= wr_data;
      end
    end
    assign banks[g] = BANK_W'({hi_q, lo_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= GRAN_8K;
      mirror_q <= 2'd0;
    end else begin
      if (ctrl_hit) mode_q <= gran_e'(wr_data[4:3]);
      if (mirr_hit) mirror_q <= wr_data[1:0];
    end
  end

  // R7: the mirroring code follows the data of a mirroring write
  p_mirror_load_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ((wr_addr & DEC_MASK) == MIRR_ADDR)) |=> mirror_q == $past(wr_data[1:0]));

  // R2: granularity changes only through a control write
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ((wr_addr & DEC_MASK) == CTRL_ADDR)) |=> $stable(mode_q));

  // R8: reset leaves granularity 0 and vertical mirroring
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (mode_q == GRAN_8K && mirror_q == 2'd0));
endmodule

// File: rtl/chrmap_page_calc.sv
module chrmap_page_calc
  import chrmap_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 16
) (
  input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
  input  gran_e                            mode,
  input  logic [2:0]                       slot,
  output logic [BANK_W-1:0]                page
);
  always_comb begin
    unique case (mode)
      GRAN_8K: page = {banks[0][BANK_W-4:0], 3'b000} + BANK_W'(slot);
      GRAN_4K: page = {banks[{slot[2], 2'b00}][BANK_W-3:0], slot[1:0]};
      GRAN_2K: page = {banks[{slot[2:1], 1'b0}][BANK_W-2:0], slot[0]};
      default: page = banks[slot];
    endcase
  end
endmodule

// File: rtl/pattern_page_mapper.sv
module pattern_page_mapper
  import chrmap_pkg::*;
#(
  parameter int PAGE_COUNT = 300,
  parameter int NUM_BANKS  = 8,
  parameter int BANK_W     = 16,
  parameter int PAGE_W     = $clog2(PAGE_COUNT),
  parameter int ROM_AW     = PAGE_W + 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [12:0]       vid_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [1:0]        mirror_sel
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
  gran_e                            mode;
  logic [BANK_W-1:0]                page;
  logic [PAGE_W-1:0]                page_idx;

  chrmap_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .banks(banks), .mode_q(mode), .mirror_q(mirror_sel)
  );

  chrmap_page_calc #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_calc (
    .banks(banks), .mode(mode), .slot(vid_addr[12:10]), .page(page)
  );

  assign page_idx = PAGE_W'(page % BANK_W'(PAGE_COUNT));

  always_ff @(posedge clk) begin
    if (rst) rom_addr <= '0;
    else     rom_addr <= {page_idx, vid_addr[9:0]};
  end

  // R9: byte offset passes through with one cycle of latency
  p_offset_pass_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rom_addr[9:0] == $past(vid_addr[9:0]));

  // R9: the registered page index never exceeds the ROM page count
  p_page_range_r9: assert property (@(posedge clk) disable iff (rst)
    rom_addr[ROM_AW-1:10] < PAGE_COUNT);

  // R3: in 8 KB granularity the low page bits equal the slot
  p_slot_low_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == GRAN_8K) |-> page[2:0] == vid_addr[12:10]);

  // R5: in 2 KB granularity page parity follows slot parity
  p_pair_parity_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == GRAN_2K) |-> page[0] == vid_addr[10]);
endmodule

// File: tb/pattern_page_mapper_bench.sv
module pattern_page_mapper_bench;
  localparam int PAGE_COUNT = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [12:0] vid_addr = '0;
  logic [18:0] rom_addr;
  logic [1:0]  mirror_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_lo[8];
  int m_hi[8];
  int m_mode = 0;
  int m_mir = 0;

  always #10 clk = ~clk;

  pattern_page_mapper #(.PAGE_COUNT(PAGE_COUNT)) u_pattern_page_mapper (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vid_addr(vid_addr), .rom_addr(rom_addr), .mirror_sel(mirror_sel)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bank(int i);
    return m_hi[i] * 256 + m_lo[i];
  endfunction

  function automatic int exp_page(int s);
    int p;
    case (m_mode)
      0: p = bank(0) * 8 + s;
      1: p = (s < 4) ? bank(0) * 4 + s : bank(4) * 4 + (s - 4);
      2: p = bank((s / 2) * 2) * 2 + (s % 2);
      default: p = bank(s);
    endcase
    return (p % 65536) % PAGE_COUNT;
  endfunction

  function automatic string mode_req();
    case (m_mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    m_mode = 0;
    m_mir = 0;
  endtask

  task automatic wr(int a, int d);
    int m;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    m = a & 16'hF007;
    if (m >= 16'h9000 && m <= 16'h9007) m_lo[m & 7] = d & 255;
    if (m >= 16'hA000 && m <= 16'hA007) m_hi[m & 7] = d & 255;
    if (m == 16'hD000) m_mode = (d >> 3) & 3;
    if (m == 16'hD001) m_mir = d & 3;
  endtask

  task automatic probe(int v, string req);
    @(negedge clk);
    vid_addr = 13'(v);
    @(negedge clk);
    check(req, int'(rom_addr), exp_page((v >> 10) & 7) * 1024 + (v & 1023));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    check("R8 rom_addr", int'(rom_addr), 0);
    check("R8 mirror", int'(mirror_sel), 0);
    probe(13'h1C05, "R8 zero banks");

    // R1: high byte extends bank number (1 KB granularity)
    wr(16'hD000, 8'h18);
    wr(16'h9000, 8'h00);
    wr(16'hA000, 8'h01);
    probe(13'h0123, "R1");
    wr(16'h9007, 8'h2A);
    probe(13'h1F00, "R1 R6");

    // R10: unmapped writes ignored, masked aliasing
    wr(16'hB000, 8'h55);
    wr(16'hC005, 8'h33);
    wr(16'hD002, 8'h1F);
    probe(13'h0010, "R10 unmapped");
    check("R10 mirror", int'(mirror_sel), 0);
    wr(16'h9FF8, 8'h07);
    probe(13'h0010, "R10 alias");

    // R2: only bits 4:3 of control matter
    wr(16'hD000, 8'h67);
    probe(13'h0C00, "R2 bits");
    check("R2 mode0 page", m_mode, 0);
    wr(16'hD000, 8'h70);
    probe(13'h1400, "R2 mode2");

    // R7: all mirroring codes
    for (int k = 0; k < 4; k++) begin
      wr(16'hD001, 8'hFC | k);
      check("R7", int'(mirror_sel), k);
    end

    // R3 R9: 16-bit wrap at page 0xFFFF
    wr(16'hD000, 8'h00);
    wr(16'h9000, 8'hFF);
    wr(16'hA000, 8'hFF);
    probe(13'h1FFF, "R3 R9 wrap");
    // R4: upper window uses bank 4
    wr(16'hD000, 8'h08);
    wr(16'h9004, 8'h11);
    wr(16'hA004, 8'h00);
    probe(13'h1400, "R4");
    probe(13'h0400, "R4 low");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: wr(16'h9000 | int'($urandom_range(0, 7)), int'($urandom_range(0, 255)));
        3:       wr(16'hA000 | int'($urandom_range(0, 7)),
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 1)));
        4:       wr(16'hD000, int'($urandom_range(0, 255)));
        5:       wr(16'hD001, int'($urandom_range(0, 255)));
        6:       wr(int'($urandom_range(0, 65535)), int'($urandom_range(0, 255)));
        default: ;
      endcase
      probe(int'($urandom_range(0, 8191)), {mode_req(), " R9"});
      check("R7 rand", int'(mirror_sel), m_mir);
    end

    // R8: reset mid-run
    wr(16'hD001, 8'h03);
    do_reset();
    check("R8 mirror after", int'(mirror_sel), 0);
    check("R8 addr after", int'(rom_addr), 0);
    probe(13'h0BFF, "R8 banks after");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule